// File: doc/BRIEF.md
# Credit-Limited Macroblock Dispatcher

This block walks one raw intraframe image, held in an external frame memory, macroblock by macroblock. For each macroblock it fetches the first luma line from memory and offers it downstream on a valid/ready channel. The offer also carries the macroblock's row and column indices and a coded-block-pattern field. A credit counter bounds how many macroblocks may be inside the downstream encoding pipeline at once. Every completion acknowledgement coming back from the end of that pipeline returns one credit.

A one-cycle frame-start strobe launches a frame. When credit runs out the block parks in a wait state and fetches nothing until an acknowledgement comes back. After the last macroblock of the frame has been taken downstream, it pulses frame-done and returns to idle. A start strobe that arrives while a frame is still in progress does not restart the walk; it is reported on an overrun output.

Top module: `mbd_dispatch`

## Requirements
- R1: After reset the block is idle: `mb_valid`, `mem_rd_en`, `frame_done` and `overrun` are low, and the credit count is at its full value of 5.
- R2: A frame issues 99 macroblocks in row-major order over an 11-column by 9-row grid. The column index counts 0 to 10 first; the row index then steps, from 0 to 8.
- R3: A macroblock is only issued (accepted with `mb_valid` and `mb_ready` high) while credit is above zero. Each issue takes one credit, so with no acknowledgements at most 5 macroblocks are issued and the block then stalls with `mb_valid` low.
- R4: Each cycle with `mb_ack` high returns one credit. A stalled block resumes fetching and issuing after an acknowledgement. An issue and an acknowledgement in the same cycle leave the count unchanged.
- R5: Acknowledgements are counted in every state, including idle. The credit count never rises above 5; acknowledgements that would push it higher have no effect.
- R6: For the macroblock at (row r, column c), the block reads 4 consecutive 32-bit words starting at word address r*704 + c*4. The memory returns data one cycle after `mem_rd_en`. Word k appears on `mb_pixels[32k+31:32k]`.
- R7: `mb_cbp` is 0 on every issued macroblock.
- R8: While `mb_valid` is high and `mb_ready` is low, the next cycle still has `mb_valid` high with row, column and pixels unchanged.
- R9: `frame_done` is high for exactly one cycle, the cycle after the last macroblock's handshake. The block is then idle and accepts a new `frame_start`.
- R10: A `frame_start` that arrives while a frame is in progress does not disturb the walk. `overrun` goes high for one cycle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe: a frame is ready in memory |
| overrun | output | 1 | One-cycle flag: a start strobe arrived during a frame |
| mem_rd_en | output | 1 | Frame memory read enable |
| mem_rd_addr | output | 14 | Frame memory word address |
| mem_rd_data | input | 32 | Frame memory read data, one cycle after the enable |
| mb_valid | output | 1 | Macroblock offer valid |
| mb_ready | input | 1 | Downstream accepts the offer |
| mb_row | output | 4 | Macroblock row index |
| mb_col | output | 4 | Macroblock column index |
| mb_cbp | output | 6 | Coded-block-pattern field |
| mb_pixels | output | 128 | First luma line of the macroblock |
| mb_ack | input | 1 | Completion acknowledgement; returns one credit |
| frame_done | output | 1 | One-cycle pulse after the last macroblock is accepted |

## Verification
The bench starves the block of acknowledgements and checks that it stops after exactly five issues and then takes exactly one more step for a single acknowledgement. A counter that ignored credit would run on, and one that lost a simultaneous issue and acknowledgement would drift. Acknowledgements are returned while the block is idle, with a surplus beyond the pipeline depth. The next starved frame must then issue exactly five: a design that drops idle acknowledgements issues fewer, and one without a ceiling issues more. Irregular ready patterns test that the offer is held stable under backpressure. A mid-frame start strobe checks the overrun flag and shows that the walk neither restarts nor skips.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_FETCH = 2'd2,
    ST_OFFER = 2'd3
  } disp_state_t;

endpackage

// File: rtl/mbd_credit.sv
module mbd_credit #(
  parameter int CREDITS = 5,
  localparam int CR_W = $clog2(CREDITS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic            give,
  output logic            has_credit,
  output logic [CR_W-1:0] level
);

  logic [CR_W-1:0] count;
  logic [CR_W:0]   sum;

  always_comb begin
    sum = {1'b0, count} + {{CR_W{1'b0}}, give} - {{CR_W{1'b0}}, take};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= CR_W'(CREDITS);
    end else if (sum > (CR_W+1)'(CREDITS)) begin
      count <= CR_W'(CREDITS);
    end else begin
      count <= sum[CR_W-1:0];
    end
  end

  assign has_credit = (count != '0);
  assign level      = count;

  // R5
  credit_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CR_W'(CREDITS));

  // R3
  no_issue_without_credit_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> count != '0);

  // R4
  ack_returns_credit_chk: assert property (@(posedge clk) disable iff (rst)
    (give && !take && count < CR_W'(CREDITS)) |=> count == $past(count) + 1'b1);

endmodule

// File: rtl/mbd_scan.sv
module mbd_scan #(
  parameter int MB_COLS    = 11,
  parameter int MB_ROWS    = 9,
  parameter int ROW_STRIDE = 704,
  parameter int COL_STRIDE = 4,
  parameter int ROW_W      = 4,
  parameter int COL_W      = 4,
  parameter int ADDR_W     = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              advance,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output logic              last,
  output logic [ADDR_W-1:0] base
);

  logic col_end;
  logic row_end;

  assign col_end = (col == COL_W'(MB_COLS - 1));
  assign row_end = (row == ROW_W'(MB_ROWS - 1));
  assign last    = col_end && row_end;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      row <= '0;
      col <= '0;
    end else if (advance) begin
      if (col_end) begin
        col <= '0;
        row <= row_end ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  assign base = ADDR_W'(row) * ADDR_W'(ROW_STRIDE) + ADDR_W'(col) * ADDR_W'(COL_STRIDE);

  // R2
  grid_bounds_chk: assert property (@(posedge clk) disable iff (rst)
    (col < COL_W'(MB_COLS)) && (row < ROW_W'(MB_ROWS)));

  // R2
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !clear && col_end && !row_end) |=> (col == '0) && (row == $past(row) + 1'b1));

endmodule

// File: rtl/mbd_fetch.sv
module mbd_fetch #(
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 14,
  localparam int IDX_W     = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         go,
  input  logic [ADDR_W-1:0]            base,
  output logic                         rd_en,
  output logic [ADDR_W-1:0]            rd_addr,
  input  logic [DATA_W-1:0]            rd_data,
  output logic [LINE_WORDS*DATA_W-1:0] payload,
  output logic                         done
);

  logic             busy;
  logic [IDX_W-1:0] req_idx;
  logic             cap_vld;
  logic [IDX_W-1:0] cap_idx;
  logic [DATA_W-1:0] words [LINE_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      req_idx <= '0;
    end else if (go) begin
      busy    <= 1'b1;
      req_idx <= '0;
    end else if (busy) begin
      if (req_idx == IDX_W'(LINE_WORDS - 1)) begin
        busy <= 1'b0;
      end
      req_idx <= req_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_vld <= 1'b0;
      cap_idx <= '0;
    end else begin
      cap_vld <= busy;
      cap_idx <= req_idx;
    end
  end

  assign rd_en   = busy;
  assign rd_addr = base + ADDR_W'(req_idx);
  assign done    = cap_vld && (cap_idx == IDX_W'(LINE_WORDS - 1));

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        words[w] <= '0;
      end else if (cap_vld && cap_idx == IDX_W'(w)) begin
        words[w] <= rd_data;
      end
    end
    assign payload[w*DATA_W +: DATA_W] = words[w];
  end

  // R6
  fetch_not_reentered_chk: assert property (@(posedge clk) disable iff (rst)
    go |-> !busy && !cap_vld);

  // R6
  capture_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    cap_vld |-> $past(rd_en));

endmodule

// File: rtl/mbd_dispatch.sv
module mbd_dispatch
  import mbd_pkg::*;
#(
  parameter int MB_COLS    = 11,
  parameter int MB_ROWS    = 9,
  parameter int MB_SIZE    = 16,
  parameter int WORD_BYTES = 4,
  parameter int CREDITS    = 5,
  parameter int CBP_W      = 6,
  localparam int IMG_W       = MB_COLS * MB_SIZE,
  localparam int FRAME_BYTES = IMG_W * MB_ROWS * MB_SIZE * 3 / 2,
  localparam int ADDR_W      = $clog2(FRAME_BYTES / WORD_BYTES),
  localparam int DATA_W      = WORD_BYTES * 8,
  localparam int LINE_WORDS  = MB_SIZE / WORD_BYTES,
  localparam int ROW_W       = (MB_ROWS > 1) ? $clog2(MB_ROWS) : 1,
  localparam int COL_W       = (MB_COLS > 1) ? $clog2(MB_COLS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         frame_start,
  output logic                         overrun,
  output logic                         mem_rd_en,
  output logic [ADDR_W-1:0]            mem_rd_addr,
  input  logic [DATA_W-1:0]            mem_rd_data,
  output logic                         mb_valid,
  input  logic                         mb_ready,
  output logic [ROW_W-1:0]             mb_row,
  output logic [COL_W-1:0]             mb_col,
  output logic [CBP_W-1:0]             mb_cbp,
  output logic [LINE_WORDS*DATA_W-1:0] mb_pixels,
  input  logic                         mb_ack,
  output logic                         frame_done
);

  localparam int ROW_STRIDE = MB_SIZE * IMG_W / WORD_BYTES;
  localparam int COL_STRIDE = MB_SIZE / WORD_BYTES;
  localparam int CR_W       = $clog2(CREDITS + 1);

  disp_state_t       state;
  logic              has_credit;
  logic [CR_W-1:0]   credit_level;
  logic              issue;
  logic              fetch_go;
  logic              fetch_done;
  logic              scan_clear;
  logic              scan_last;
  logic [ADDR_W-1:0] scan_base;

  assign scan_clear = (state == ST_IDLE) && frame_start;
  assign issue      = (state == ST_OFFER) && mb_ready;
  assign fetch_go   = (state == ST_WAIT) && has_credit;

  mbd_credit #(.CREDITS(CREDITS)) u_credit (
    .clk        (clk),
    .rst        (rst),
    .take       (issue),
    .give       (mb_ack),
    .has_credit (has_credit),
    .level      (credit_level)
  );

  mbd_scan #(
    .MB_COLS    (MB_COLS),
    .MB_ROWS    (MB_ROWS),
    .ROW_STRIDE (ROW_STRIDE),
    .COL_STRIDE (COL_STRIDE),
    .ROW_W      (ROW_W),
    .COL_W      (COL_W),
    .ADDR_W     (ADDR_W)
  ) u_scan (
    .clk     (clk),
    .rst     (rst),
    .clear   (scan_clear),
    .advance (issue),
    .row     (mb_row),
    .col     (mb_col),
    .last    (scan_last),
    .base    (scan_base)
  );

  mbd_fetch #(
    .LINE_WORDS (LINE_WORDS),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W)
  ) u_fetch (
    .clk     (clk),
    .rst     (rst),
    .go      (fetch_go),
    .base    (scan_base),
    .rd_en   (mem_rd_en),
    .rd_addr (mem_rd_addr),
    .rd_data (mem_rd_data),
    .payload (mb_pixels),
    .done    (fetch_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      overrun    <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      overrun    <= frame_start && (state != ST_IDLE);
      frame_done <= 1'b0;
      unique case (state)
        ST_IDLE:  if (frame_start) state <= ST_WAIT;
        ST_WAIT:  if (has_credit) state <= ST_FETCH;
        ST_FETCH: if (fetch_done) state <= ST_OFFER;
        ST_OFFER: begin
          if (mb_ready) begin
            if (scan_last) begin
              state      <= ST_IDLE;
              frame_done <= 1'b1;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mb_valid = (state == ST_OFFER);
  assign mb_cbp   = '0;

  // R8
  offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mb_valid && !mb_ready) |=> mb_valid && $stable(mb_row) && $stable(mb_col) && $stable(mb_pixels));

  // R9
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R9
  done_after_handshake_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(mb_valid && mb_ready) && (state == ST_IDLE));

  // R10
  overrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $past(frame_start) && ($past(state) != ST_IDLE));

  // R3
  stall_without_credit_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && credit_level == '0) |=> !mem_rd_en);

endmodule

// File: tb/tb_mbd_dispatch.sv
module tb_mbd_dispatch;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         frame_start = 1'b0;
  logic         overrun;
  logic         mem_rd_en;
  logic [13:0]  mem_rd_addr;
  logic [31:0]  mem_rd_data = '0;
  logic         mb_valid;
  logic         mb_ready = 1'b0;
  logic [3:0]   mb_row;
  logic [3:0]   mb_col;
  logic [5:0]   mb_cbp;
  logic [127:0] mb_pixels;
  logic         mb_ack = 1'b0;
  logic         frame_done;

  always #2.5 clk = ~clk;

  mbd_dispatch dut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .overrun(overrun),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mb_valid(mb_valid), .mb_ready(mb_ready), .mb_row(mb_row), .mb_col(mb_col),
    .mb_cbp(mb_cbp), .mb_pixels(mb_pixels), .mb_ack(mb_ack), .frame_done(frame_done)
  );

  function automatic logic [31:0] mem_word(input logic [13:0] a);
    return (32'(a) * 32'h0001_0003) ^ 32'hC35A_0000;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_word(mem_rd_addr);

  int checks = 0, failures = 0;
  bit finished = 0;
  int exp_row[$], exp_col[$];
  int frame_count = 0, frames_done = 0, outstanding = 0, model_credit = 5;
  int ack_mode = 0, force_acks = 0, rdy_mode = 0, cyc = 0;
  bit start_req = 0, ovr_req = 0, exp_ovr = 0, exp_done = 0, prev_stall = 0;
  logic [3:0] p_row, p_col;
  logic [127:0] p_pix;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic start_frame();
    for (int r = 0; r < 9; r++)
      for (int c = 0; c < 11; c++) begin
        exp_row.push_back(r);
        exp_col.push_back(c);
      end
    frame_count = 0;
    start_req = 1;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor and input driver
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        cyc++;
        if (prev_stall) // R8
          chk(mb_valid && mb_row == p_row && mb_col == p_col && mb_pixels == p_pix,
              "R8", "offer changed under backpressure", {mb_row, mb_col, mb_pixels[7:0]}, {p_row, p_col, p_pix[7:0]});
        if (exp_done) begin
          chk(frame_done == 1'b1, "R9", "frame_done after last handshake", frame_done, 1);
          frames_done++;
        end else if (frame_done)
          chk(0, "R9", "unexpected frame_done", frame_done, 0);
        exp_done = 0;
        if (exp_ovr) chk(overrun == 1'b1, "R10", "overrun flag", overrun, 1);
        else if (overrun) chk(0, "R10", "unexpected overrun", overrun, 0);
        exp_ovr = 0;
        // drive inputs for the coming edge
        frame_start = 1'b0;
        if (start_req) begin frame_start = 1'b1; start_req = 0; end
        else if (ovr_req) begin frame_start = 1'b1; ovr_req = 0; exp_ovr = 1; end
        mb_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        mb_ack = 1'b0;
        if (force_acks > 0) begin
          mb_ack = 1'b1; force_acks--;
          if (outstanding > 0) outstanding--;
        end else if ((ack_mode == 1 && outstanding > 0) || (ack_mode == 2 && outstanding >= 3)) begin
          mb_ack = 1'b1; outstanding--;
        end
        prev_stall = mb_valid && !mb_ready;
        p_row = mb_row; p_col = mb_col; p_pix = mb_pixels;
        if (mb_valid && mb_ready) begin
          int er, ec;
          logic [127:0] ep;
          if (model_credit == 0) chk(0, "R3", "issue with no credit", 0, 1);
          if (exp_row.size() == 0) chk(0, "R2", "macroblock beyond frame", 1, 0);
          else begin
            er = exp_row.pop_front();
            ec = exp_col.pop_front();
            chk(mb_row == 4'(er) && mb_col == 4'(ec), "R2", "row/col order", {mb_row, mb_col}, {4'(er), 4'(ec)});
            for (int k = 0; k < 4; k++)
              ep[32*k +: 32] = mem_word(14'(er * 704 + ec * 4 + k));
            chk(mb_pixels == ep, "R6", "pixel payload", mb_pixels, ep);
            chk(mb_cbp == 6'd0, "R7", "cbp field", mb_cbp, 0);
          end
          frame_count++;
          outstanding++;
          if (frame_count == 99) exp_done = 1;
        end
        model_credit = model_credit - ((mb_valid && mb_ready) ? 1 : 0) + (mb_ack ? 1 : 0);
        if (model_credit > 5) model_credit = 5;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(!mb_valid && !mem_rd_en && !frame_done && !overrun, "R1", "idle outputs after reset",
        {mb_valid, mem_rd_en, frame_done, overrun}, 0);
    wait_cycles(3);
    chk(!mb_valid && !mem_rd_en, "R1", "stays idle without start", {mb_valid, mem_rd_en}, 0);

    // Frame A: eager acks, ready always (R2, R6, R7, R9)
    ack_mode = 1; rdy_mode = 0;
    start_frame();
    wait (frames_done == 1);
    wait_cycles(2);
    chk(exp_row.size() == 0, "R2", "all 99 macroblocks issued", exp_row.size(), 0);
    chk(!mb_valid && !mem_rd_en, "R9", "idle after frame", {mb_valid, mem_rd_en}, 0);

    // Frame B: starve credit (R3), single ack (R4), then lazy acks, overrun (R10)
    ack_mode = 0; rdy_mode = 1;
    start_frame();
    wait (frame_count == 5);
    wait_cycles(60);
    chk(frame_count == 5, "R3", "issues capped at credit", frame_count, 5);
    chk(!mb_valid && !mem_rd_en, "R3", "stalled with no credit", {mb_valid, mem_rd_en}, 0);
    force_acks = 1;
    wait_cycles(40);
    chk(frame_count == 6, "R4", "one ack lets one macroblock out", frame_count, 6);
    ack_mode = 2;
    wait (frame_count >= 20);
    ovr_req = 1;
    wait (frames_done == 2);
    wait_cycles(2);
    chk(exp_row.size() == 0, "R10", "walk undisturbed by overrun", exp_row.size(), 0);

    // Idle acks with surplus (R5), then starved frame C
    ack_mode = 0;
    force_acks = outstanding + 4;
    wait_cycles(20);
    chk(!mb_valid && !frame_done, "R5", "surplus acks leave block idle", {mb_valid, frame_done}, 0);
    rdy_mode = 0;
    start_frame();
    wait_cycles(80);
    chk(frame_count == 5, "R5", "idle acks restored full credit, no more", frame_count, 5);
    ack_mode = 1;
    wait (frames_done == 3);
    wait_cycles(2);
    chk(exp_row.size() == 0, "R4", "frame C completes after acks resume", exp_row.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule